// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds the architectural registers of a small processor: eight words of parameterised width, all clocked by one clock. Two read ports and one write port work side by side. Each read port takes a register number and returns that register's contents through combinational logic, so its output follows its address within the same cycle. The write port takes a register number and a data word. The addressed register takes the new word on the rising clock edge and at no other time.

Register numbers are four bits wide. The values 0 to 7 select a register. Any value of 8 or higher means "no register". A read port given such a number drives zero. A write given such a number leaves every register as it was. Because of this, an idle port needs no separate enable line: the caller parks it on a "none" number.

A synchronous active-high reset clears every register to zero. The block does no bypassing. A read of the register being written in the same cycle returns the value held before the edge.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst` is high at a rising edge, every register reads zero on both ports after that edge.
- R2: Port A output `rd_a_data` equals the contents of register `rd_a_id` (0 to 7) in the same cycle, with no clock edge between the address change and the data.
- R3: Port B output `rd_b_data` equals the contents of register `rd_b_id` (0 to 7), independently of port A.
- R4: A write with `wr_id` in 0 to 7 and `rst` low stores `wr_data` into that register at the rising edge. The stored value is readable from the cycle after.
- R5: A write with `wr_id` of 8 or higher changes no register.
- R6: A read port given an id of 8 or higher outputs zero, whatever the register contents.
- R7: Both read ports may address the same register, or different registers, in the same cycle as a write to another register, and each port still returns its own correct value.
- R8: When a read id equals the write id in the same cycle, the read returns the old value before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_id | input | ID_W | Register number for read port A (8 or higher = none) |
| rd_a_data | output | WORD_W | Read port A data |
| rd_b_id | input | ID_W | Register number for read port B (8 or higher = none) |
| rd_b_data | output | WORD_W | Read port B data |
| wr_id | input | ID_W | Register number for the write port (8 or higher = none) |
| wr_data | input | WORD_W | Word to store at the next rising edge |

## Verification
A combinational read and a clocked write can hit the same register in one cycle. The bench provokes this by driving equal read and write ids on both ports, either by direct choice or by random draws over a small id range. In that cycle the scoreboard expects the value from before the edge. On the next cycle it expects the newly written word. Each expectation comes from a shadow array that is updated only after the cycle's expectation has been queued.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

    localparam int unsigned RF_DEF_WORD_W = 32;
    localparam int unsigned RF_DEF_NREGS  = 8;
    localparam int unsigned RF_DEF_ID_W   = 4;
    localparam int unsigned RF_NUM_RD     = 2;

    // what the write side does on the coming edge
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_STORE = 2'd1,
        WR_CLEAR = 2'd2
    } wr_action_e;

endpackage

// File: rtl/rf_id_decode.sv
`timescale 1ns/1ps
module rf_id_decode #(
    parameter int unsigned ID_W     = 4,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic [ID_W-1:0]     id,
    output logic                real_reg,
    output logic [NUM_REGS-1:0] onehot
);
    // ids at or above NUM_REGS name no register
    assign real_reg = (int'(id) < NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign onehot[g] = real_reg && (int'(id) == g);
    end
endmodule

// File: rtl/rf_write_ctrl.sv
`timescale 1ns/1ps
module rf_write_ctrl
    import rf_pkg::*;
#(
    parameter int unsigned ID_W     = 4,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                rst,
    input  logic [ID_W-1:0]     wr_id,
    output wr_action_e          action,
    output logic [NUM_REGS-1:0] wr_en,
    output logic                clr
);
    logic                wr_real;
    logic [NUM_REGS-1:0] wr_sel;

    rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_wdec (
        .id       (wr_id),
        .real_reg (wr_real),
        .onehot   (wr_sel)
    );

    always_comb begin
        if (rst)          action = WR_CLEAR;
        else if (wr_real) action = WR_STORE;
        else              action = WR_IDLE;
    end

    assign wr_en = (action == WR_STORE) ? wr_sel : '0;
    assign clr   = (action == WR_CLEAR);
endmodule

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                             clk,
    input  logic                             clr,
    input  logic [NUM_REGS-1:0]              wr_en,
    input  logic [WORD_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (clr)           regs[g] <= '0;
            else if (wr_en[g]) regs[g] <= wr_data;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ID_W     = 4
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
    input  logic [ID_W-1:0]                 rd_id,
    output logic [WORD_W-1:0]               rd_data
);
    logic                rd_real;
    logic [NUM_REGS-1:0] rd_sel;

    rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rdec (
        .id       (rd_id),
        .real_reg (rd_real),
        .onehot   (rd_sel)
    );

    // AND-OR select: an empty one-hot (no register) yields zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_data = rd_data | ({WORD_W{rd_sel[i] & rd_real}} & regs[i]);
        end
    end
endmodule

// File: rtl/regfile_2r1w.sv
`timescale 1ns/1ps
module regfile_2r1w
    import rf_pkg::*;
#(
    parameter int unsigned WORD_W   = RF_DEF_WORD_W,
    parameter int unsigned NUM_REGS = RF_DEF_NREGS,
    parameter int unsigned ID_W     = RF_DEF_ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [WORD_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [WORD_W-1:0] wr_data
);
    localparam int unsigned NUM_RD = RF_NUM_RD;

    wr_action_e                      action;
    logic [NUM_REGS-1:0]             wr_en;
    logic                            clr;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    logic [NUM_RD-1:0][ID_W-1:0]     rd_id;
    logic [NUM_RD-1:0][WORD_W-1:0]   rd_data;

    rf_write_ctrl #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_wctl (
        .rst    (rst),
        .wr_id  (wr_id),
        .action (action),
        .wr_en  (wr_en),
        .clr    (clr)
    );

    rf_bank #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign rd_id[0]  = rd_a_id;
    assign rd_id[1]  = rd_b_id;
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_rp (
            .regs    (regs),
            .rd_id   (rd_id[p]),
            .rd_data (rd_data[p])
        );
    end

    logic unused_action;
    assign unused_action = ^action;
endmodule

// File: rtl/regfile_2r1w_chk.sv
`timescale 1ns/1ps
module regfile_2r1w_chk #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ID_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ID_W-1:0]   rd_a_id,
    input logic [WORD_W-1:0] rd_a_data,
    input logic [ID_W-1:0]   rd_b_id,
    input logic [WORD_W-1:0] rd_b_data,
    input logic [ID_W-1:0]   wr_id,
    input logic [WORD_W-1:0] wr_data
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (rd_a_data == '0 && rd_b_data == '0));

    // R6
    none_read_a_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_a_id) >= NUM_REGS) |-> (rd_a_data == '0));

    // R6
    none_read_b_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_b_id) >= NUM_REGS) |-> (rd_b_data == '0));

    // R4 R8
    write_lands_a_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) < NUM_REGS) |=>
        ((rd_a_id != $past(wr_id)) || (rd_a_data == $past(wr_data))));

    // R4 R8
    write_lands_b_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) < NUM_REGS) |=>
        ((rd_b_id != $past(wr_id)) || (rd_b_data == $past(wr_data))));

    // R5
    none_write_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) >= NUM_REGS) |=>
        (!$stable(rd_a_id) || $stable(rd_a_data)));
endmodule

bind regfile_2r1w regfile_2r1w_chk #(
    .WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst(rst),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_id(wr_id), .wr_data(wr_data)
);

// File: tb/regfile_2r1w_bench.sv
`timescale 1ns/1ps
module regfile_2r1w_bench;
    localparam int W      = 32;
    localparam int NREG   = 8;
    localparam real PERIOD = 8.0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   rd_a_id = '0, rd_b_id = '0, wr_id = 4'd8;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_a_data, rd_b_data;

    always #(PERIOD/2) clk = ~clk;

    regfile_2r1w #(.WORD_W(W), .NUM_REGS(NREG), .ID_W(4)) u_regfile_2r1w (
        .clk(clk), .rst(rst),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    typedef struct {
        logic [W-1:0] exp_a;
        logic [W-1:0] exp_b;
        int           id_a;
        int           id_b;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [W-1:0] shadow [NREG];
    int           total = 0;
    int           bad   = 0;

    function automatic logic [W-1:0] model_rd(input int id);
        return (id < NREG) ? shadow[id] : '0;
    endfunction

    // driver: applies one cycle of stimulus and queues what the reads must show
    task automatic step(input logic r, input int a, input int b, input int w,
                        input logic [W-1:0] d, input string tag, input bit chk);
        exp_t e;
        @(negedge clk);
        rst = r; rd_a_id = 4'(a); rd_b_id = 4'(b); wr_id = 4'(w); wr_data = d;
        if (chk) begin
            e.exp_a = model_rd(a); e.exp_b = model_rd(b);
            e.id_a = a; e.id_b = b; e.tag = tag;
            sb_q.push_back(e);
        end
        // state seen from the next cycle on
        if (r) begin
            for (int i = 0; i < NREG; i++) shadow[i] = '0;
        end else if (w < NREG) begin
            shadow[w] = d;
        end
    endtask

    // monitor: samples mid-cycle, before the rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                total++;
                if (rd_a_data !== e.exp_a) begin
                    bad++;
                    $display("FAIL %s port A id=%0d actual=%h expected=%h",
                             e.tag, e.id_a, rd_a_data, e.exp_a);
                end
                total++;
                if (rd_b_data !== e.exp_b) begin
                    bad++;
                    $display("FAIL %s port B id=%0d actual=%h expected=%h",
                             e.tag, e.id_b, rd_b_data, e.exp_b);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 50000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) shadow[i] = '0;
        step(1, 0, 0, 8, '0, "reset", 0);
        step(1, 0, 0, 8, '0, "reset", 0);

        // R1: everything reads zero after reset
        for (int i = 0; i < NREG; i++) step(0, i, NREG-1-i, 8, '0, "R1 reset clear", 1);

        // R4 R8: same-cycle read of the written register shows old, then new
        for (int i = 0; i < NREG; i++)
            step(0, i, i, i, 32'hA5A5_0000 + W'(i * 32'h111), "R8 same-cycle old", 1);
        for (int i = 0; i < NREG; i++) step(0, i, (i+3)%NREG, 8, '0, "R4 write landed", 1);

        // R2 R3: independent ports, combinational address changes
        for (int i = 0; i < NREG; i++) step(0, (i*5)%NREG, (i*3+1)%NREG, 8, '0, "R2/R3 reads", 1);

        // R6: none ids read zero though registers hold data
        step(0, 8, 15, 8, '0, "R6 none read", 1);
        step(0, 12, 0, 8, '0, "R6 none read", 1);
        step(0, 0, 9, 8, '0, "R6 none read", 1);

        // R5: writes to none ids change nothing
        step(0, 0, 1, 8,  32'hDEAD_BEEF, "R5 none write", 1);
        step(0, 2, 3, 13, 32'hDEAD_BEEF, "R5 none write", 1);
        step(0, 4, 5, 15, 32'hDEAD_BEEF, "R5 none write", 1);
        for (int i = 0; i < NREG; i++) step(0, i, i, 8, '0, "R5 none write", 1);

        // R7: both ports on one register while another is written
        step(0, 6, 6, 2, 32'h1234_5678, "R7 shared read", 1);
        step(0, 2, 2, 6, 32'h8765_4321, "R7 shared read", 1);
        step(0, 2, 6, 8, '0, "R7 shared read", 1);

        // R1: reset in mid-run
        step(1, 3, 4, 5, 32'hFFFF_FFFF, "R1 mid reset", 1);
        for (int i = 0; i < NREG; i++) step(0, i, i, 8, '0, "R1 mid reset", 1);

        // R2 R3 R8: random traffic with many id collisions
        for (int n = 0; n < 400; n++)
            step(0, int'($urandom_range(0, 9)), int'($urandom_range(0, 9)),
                 int'($urandom_range(0, 9)), W'($urandom), "R2/R3/R8 random", 1);

        step(0, 8, 8, 8, '0, "drain", 0);
        @(negedge clk); #3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule